// File: doc/BRIEF.md
# Status Latch and Event Counter Register Bank

A 32-bit register bank that software reaches over a simple synchronous bus. It holds three kinds of state. Status latch registers capture one-cycle event pulses from the surrounding logic. Event counters count single-bit event strobes. An identification word and a global configuration word complete the bank. The clear behaviour of each status register and each counter is a parameter. The choices are: cleared by a read, cleared by a write, cleared by whichever of the two a configuration bit selects, or cleared by a read only when a second configuration bit allows it. Each counter is built either to stop at its maximum or to wrap to zero.

Every status register has an enable register beside it and is assigned to one of three interrupt levels, where level 1 is the lowest. An interrupt output is high while any enabled latched bit of its level is set. Reads return data one cycle after the request. A read of an address that holds no register returns zero and changes nothing.

Default map (byte addresses, 32-bit words): 0x00 identification, 0x04 configuration. Status 0, 1 and 2 sit at 0x08, 0x10 and 0x18, with their enables at 0x0C, 0x14 and 0x1C. Counters 0 to 3 sit at 0x20, 0x24, 0x28 and 0x2C. By default, status 0 clears on read and drives level 1; status 1 clears on write and drives level 2; status 2 uses the selectable read-or-write clear and drives level 3. Counter 0 saturates and clears on read. Counter 1 wraps and clears on write. Counter 2 saturates and uses the read-or-never clear. Counter 3 wraps and uses the selectable read-or-write clear. Status registers are STAT_W = 8 bits wide and counters CNT_W = 8 bits wide, both zero-extended on read.

Top module: `sc_regbank`

## Requirements
- R1: The word at 0x00 is read-only and reads {12'h000, ID_VAL, 4'h0}, which is 0x000A5C30 with the default ID_VAL of 16'hA5C3. A write to 0x00 changes nothing.
- R2: The configuration word at 0x04 resets to 0x00000800. Only bits 0, 1 and 11 are writable, and every other bit reads zero. Bit 0 (write-select) chooses the write as the clear action of read-or-write registers; when it is 0, the read is the clear action. Bit 1 (read-clear-enable) lets a read clear the read-or-never counters.
- R3: A status bit is set by a high event input at a clock edge and then holds until its register's clear action. A bus write to a status register whose clear action is a read neither sets nor clears any bit.
- R4: A read of a clear-on-read register returns its current value and leaves it at zero for the next cycle.
- R5: A write of any data to a clear-on-write register sets it to zero. A read of that register leaves it unchanged.
- R6: A read-or-write register is cleared by a read when configuration bit 0 is 0 and by a write when it is 1. This holds for both status registers and counters.
- R7: When an event and the clear action hit the same register in the same cycle, the read returns the value from before the clear. Afterwards a status bit hit by the event is 1, and a counter is 1.
- R8: A saturating counter stays at 2^CNT_W-1 (255 by default) when further events arrive.
- R9: A wrapping counter goes from 2^CNT_W-1 to 0 on the next event and keeps counting from there.
- R10: A read-or-never counter is cleared by a read only when configuration bit 1 is 1. When that bit is 0, neither reads nor writes clear it.
- R11: Interrupt output irq[L-1] is a register that holds the OR, over every status register assigned to level L, of the latched bits ANDed with that register's enable word. It rises one cycle after a latched bit that is enabled goes high, and it falls one cycle after the last such bit clears.
- R12: bus_rdata carries the addressed word in the cycle after bus_rd is high, and is zero in the cycle after a cycle with no read. Reads of unmapped or misaligned addresses return zero and clear nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| stat_evt | input | N_STAT*STAT_W | Event pulses, one per status bit, register i at bits [i*STAT_W +: STAT_W] |
| cnt_evt | input | N_CNT | Event strobes, one per counter |
| irq | output | 3 | Interrupt levels 1 to 3 on bits 0 to 2 |

## Verification
An incoming event and a bus clear can land on the same register in the same edge. In that case the bench must see both the old value on the read port and the event kept in the register. The bench provokes this by holding an event input high during the single cycle in which it issues a clearing read. It does this for a status register and for a counter. It then judges the result with a second read, which must return the new event alone: a bit for the status register and a count of one for the counter. Bus writes and reads that land on the configuration word, the clear select and the interrupt enables are also interleaved with event activity. The bench checks that every clear follows the configuration value in force at that edge.

// File: rtl/sc_regbank_pkg.sv
package sc_regbank_pkg;

   // Clear kinds, two bits per register in the parameter vectors.
   typedef enum logic [1:0] {
      CLR_RD         = 2'd0,
      CLR_WR         = 2'd1,
      CLR_RD_OR_WR   = 2'd2,
      CLR_RD_OR_NONE = 2'd3
   } clr_kind_e;

   localparam int          CFG_WSEL_BIT = 0;
   localparam int          CFG_RCLR_BIT = 1;
   localparam logic [31:0] CFG_RESET    = 32'h0000_0800;
   localparam logic [31:0] CFG_WMASK    = 32'h0000_0803;

   function automatic logic clr_fire(input logic [1:0] kind,
                                     input logic rd_hit,
                                     input logic wr_hit,
                                     input logic wsel,
                                     input logic rclr_en);
      logic f;
      case (kind)
         CLR_RD:       f = rd_hit;
         CLR_WR:       f = wr_hit;
         CLR_RD_OR_WR: f = wsel ? wr_hit : rd_hit;
         default:      f = rclr_en & rd_hit;
      endcase
      return f;
   endfunction

endpackage

// File: rtl/sc_stat_reg.sv
module sc_stat_reg
   import sc_regbank_pkg::*;
#(
   parameter int         W   = 8,
   parameter logic [1:0] CLR = 2'd0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         rd_hit,
   input  logic         wr_hit,
   input  logic         cfg_wsel,
   input  logic         cfg_rclr,
   output logic [W-1:0] q
);

   logic clr;

   assign clr = clr_fire(CLR, rd_hit, wr_hit, cfg_wsel, cfg_rclr);

   // event OR-ed after the clear: an event in the clear cycle survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (clr ? '0 : q) | evt;
   end

endmodule

// File: rtl/sc_evt_cnt.sv
module sc_evt_cnt
   import sc_regbank_pkg::*;
#(
   parameter int         W   = 8,
   parameter bit         SAT = 1'b1,
   parameter logic [1:0] CLR = 2'd0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         evt,
   input  logic         rd_hit,
   input  logic         wr_hit,
   input  logic         cfg_wsel,
   input  logic         cfg_rclr,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] MAXV = {W{1'b1}};

   logic         clr;
   logic [W-1:0] inc;

   assign clr = clr_fire(CLR, rd_hit, wr_hit, cfg_wsel, cfg_rclr);

   generate
      if (SAT) begin : g_sat
         assign inc = (q == MAXV) ? q : q + W'(1);
      end else begin : g_wrap
         assign inc = q + W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= evt ? W'(1) : '0;
      else if (evt) q <= inc;
   end

endmodule

// File: rtl/sc_irq_merge.sv
module sc_irq_merge #(
   parameter int               N   = 3,
   parameter int               W   = 8,
   parameter logic [2*N-1:0]   LVL = 6'b11_10_01
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N*W-1:0] stat,
   input  logic [N*W-1:0] en,
   output logic [2:0]   irq
);

   logic [2:0] lvl_any;

   always_comb begin
      lvl_any = '0;
      for (int l = 0; l < 3; l++) begin
         for (int i = 0; i < N; i++) begin
            if (LVL[2*i +: 2] == 2'(l + 1))
               lvl_any[l] = lvl_any[l] | (|(stat[i*W +: W] & en[i*W +: W]));
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= '0;
      else        irq <= lvl_any;
   end

endmodule

// File: rtl/sc_regbank.sv
module sc_regbank
   import sc_regbank_pkg::*;
#(
   parameter int               ADDR_W   = 8,
   parameter int               N_STAT   = 3,
   parameter int               STAT_W   = 8,
   parameter int               N_CNT    = 4,
   parameter int               CNT_W    = 8,
   parameter logic [15:0]      ID_VAL   = 16'hA5C3,
   parameter logic [2*N_STAT-1:0] STAT_CLR = 6'b10_01_00,
   parameter logic [2*N_STAT-1:0] STAT_LVL = 6'b11_10_01,
   parameter logic [N_CNT-1:0]    CNT_SAT  = 4'b0101,
   parameter logic [2*N_CNT-1:0]  CNT_CLR  = 8'b10_11_01_00
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [31:0]              bus_wdata,
   output logic [31:0]              bus_rdata,
   input  logic [N_STAT*STAT_W-1:0] stat_evt,
   input  logic [N_CNT-1:0]         cnt_evt,
   output logic [2:0]               irq
);

   localparam int          WORD_W  = ADDR_W - 2;
   localparam int          N_WORDS = 2 + 2*N_STAT + N_CNT;
   localparam int          IX_STAT = 2;
   localparam int          IX_CNT  = 2 + 2*N_STAT;
   localparam logic [31:0] ID_WORD = {12'h000, ID_VAL, 4'h0};

   // ---------------- elaboration checks ----------------
   generate
      if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_aw
         $error("sc_regbank: ADDR_W out of range");
      end
      if (STAT_W < 1 || STAT_W > 32) begin : g_bad_sw
         $error("sc_regbank: STAT_W must be 1..32");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cw
         $error("sc_regbank: CNT_W must be 1..32");
      end
      if (N_STAT < 1 || N_CNT < 1) begin : g_bad_n
         $error("sc_regbank: need at least one status register and one counter");
      end
      if (N_WORDS > (1 << WORD_W)) begin : g_bad_map
         $error("sc_regbank: register map exceeds address space");
      end
      for (genvar i = 0; i < N_STAT; i++) begin : g_chk_stat
         if (STAT_CLR[2*i +: 2] == 2'd3) begin : g_bad_kind
            $error("sc_regbank: read-or-never clear is for counters only");
         end
         if (STAT_LVL[2*i +: 2] == 2'd0) begin : g_bad_lvl
            $error("sc_regbank: interrupt level must be 1..3");
         end
      end
   endgenerate

   // ---------------- address decode ----------------
   logic [WORD_W-1:0]  word;
   logic               aligned;
   logic [N_WORDS-1:0] rd_sel;
   logic [N_WORDS-1:0] wr_sel;

   assign word    = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);

   generate
      for (genvar k = 0; k < N_WORDS; k++) begin : g_dec
         assign rd_sel[k] = bus_rd & aligned & (word == WORD_W'(k));
         assign wr_sel[k] = bus_wr & aligned & (word == WORD_W'(k));
      end
   endgenerate

   // ---------------- configuration word ----------------
   logic [31:0] cfg_q;
   logic        cfg_wsel;
   logic        cfg_rclr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= CFG_RESET;
      else if (wr_sel[1]) cfg_q <= (bus_wdata & CFG_WMASK) | (cfg_q & ~CFG_WMASK);
   end

   assign cfg_wsel = cfg_q[CFG_WSEL_BIT];
   assign cfg_rclr = cfg_q[CFG_RCLR_BIT];

   // ---------------- status latches and enables ----------------
   logic [N_STAT*STAT_W-1:0] stat_q;
   logic [N_STAT*STAT_W-1:0] en_q;

   generate
      for (genvar i = 0; i < N_STAT; i++) begin : g_stat
         sc_stat_reg #(
            .W   (STAT_W),
            .CLR (STAT_CLR[2*i +: 2])
         ) u_stat (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (stat_evt[i*STAT_W +: STAT_W]),
            .rd_hit   (rd_sel[IX_STAT + 2*i]),
            .wr_hit   (wr_sel[IX_STAT + 2*i]),
            .cfg_wsel (cfg_wsel),
            .cfg_rclr (cfg_rclr),
            .q        (stat_q[i*STAT_W +: STAT_W])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               en_q[i*STAT_W +: STAT_W] <= '0;
            else if (wr_sel[IX_STAT + 2*i + 1])
               en_q[i*STAT_W +: STAT_W] <= bus_wdata[STAT_W-1:0];
         end
      end
   endgenerate

   // ---------------- event counters ----------------
   logic [N_CNT*CNT_W-1:0] cnt_q;

   generate
      for (genvar j = 0; j < N_CNT; j++) begin : g_cnt
         sc_evt_cnt #(
            .W   (CNT_W),
            .SAT (CNT_SAT[j]),
            .CLR (CNT_CLR[2*j +: 2])
         ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (cnt_evt[j]),
            .rd_hit   (rd_sel[IX_CNT + j]),
            .wr_hit   (wr_sel[IX_CNT + j]),
            .cfg_wsel (cfg_wsel),
            .cfg_rclr (cfg_rclr),
            .q        (cnt_q[j*CNT_W +: CNT_W])
         );
      end
   endgenerate

   // ---------------- interrupts ----------------
   sc_irq_merge #(
      .N   (N_STAT),
      .W   (STAT_W),
      .LVL (STAT_LVL)
   ) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .stat  (stat_q),
      .en    (en_q),
      .irq   (irq)
   );

   // ---------------- read path ----------------
   logic [31:0] rmux;

   always_comb begin
      rmux = '0;
      if (rd_sel[0]) rmux = ID_WORD;
      if (rd_sel[1]) rmux = cfg_q;
      for (int i = 0; i < N_STAT; i++) begin
         if (rd_sel[IX_STAT + 2*i])     rmux[STAT_W-1:0] = stat_q[i*STAT_W +: STAT_W];
         if (rd_sel[IX_STAT + 2*i + 1]) rmux[STAT_W-1:0] = en_q[i*STAT_W +: STAT_W];
      end
      for (int j = 0; j < N_CNT; j++) begin
         if (rd_sel[IX_CNT + j]) rmux[CNT_W-1:0] = cnt_q[j*CNT_W +: CNT_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rmux;
   end

endmodule

// File: rtl/sc_regbank_chk.sv
module sc_regbank_chk #(
   parameter int          ADDR_W  = 8,
   parameter int          N_STAT  = 3,
   parameter int          STAT_W  = 8,
   parameter int          N_CNT   = 4,
   parameter int          CNT_W   = 8,
   parameter logic [15:0] ID_VAL  = 16'hA5C3,
   parameter logic [N_CNT-1:0] CNT_SAT = 4'b0101
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic                     bus_rd,
   input logic                     bus_wr,
   input logic [31:0]              bus_rdata,
   input logic [N_STAT*STAT_W-1:0] stat_evt,
   input logic [N_STAT*STAT_W-1:0] stat_q,
   input logic [N_CNT-1:0]         cnt_evt,
   input logic [N_CNT*CNT_W-1:0]   cnt_q
);

   localparam int             N_WORDS = 2 + 2*N_STAT + N_CNT;
   localparam logic [CNT_W-1:0] MAXV  = {CNT_W{1'b1}};

   logic unmapped;
   assign unmapped = (bus_addr[1:0] != 2'b00) ||
                     (int'(bus_addr[ADDR_W-1:2]) >= N_WORDS);

   // R1
   a_r1_id_word: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == '0) |=> bus_rdata == {12'h000, ID_VAL, 4'h0});

   // R2
   a_r2_cfg_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(4)) |=> (bus_rdata[31:12] == '0 && bus_rdata[10:2] == '0));

   // R12
   a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == '0);

   a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && unmapped) |=> bus_rdata == '0);

   generate
      for (genvar b = 0; b < N_STAT*STAT_W; b++) begin : g_sa
         // R3 and R7: an event always leaves its bit set
         a_r3_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
            stat_evt[b] |=> stat_q[b]);
      end
      for (genvar j = 0; j < N_CNT; j++) begin : g_ca
         if (CNT_SAT[j]) begin : g_s
            a_r8_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
               (cnt_q[j*CNT_W +: CNT_W] == MAXV && !bus_rd && !bus_wr)
               |=> cnt_q[j*CNT_W +: CNT_W] == MAXV);
         end else begin : g_w
            a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
               (cnt_q[j*CNT_W +: CNT_W] == MAXV && cnt_evt[j] && !bus_rd && !bus_wr)
               |=> cnt_q[j*CNT_W +: CNT_W] == '0);
         end
      end
   endgenerate

endmodule

bind sc_regbank sc_regbank_chk #(
   .ADDR_W  (ADDR_W),
   .N_STAT  (N_STAT),
   .STAT_W  (STAT_W),
   .N_CNT   (N_CNT),
   .CNT_W   (CNT_W),
   .ID_VAL  (ID_VAL),
   .CNT_SAT (CNT_SAT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_rdata (bus_rdata),
   .stat_evt  (stat_evt),
   .stat_q    (stat_q),
   .cnt_evt   (cnt_evt),
   .cnt_q     (cnt_q)
);

// File: tb/sim_sc_regbank.sv
`timescale 1ns/1ps
module sim_sc_regbank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [23:0] stat_evt = '0;
   logic [3:0]  cnt_evt = '0;
   logic [2:0]  irq;

   int n_chk  = 0;
   int n_fail = 0;
   logic [31:0] d;

   always #2 clk = ~clk;

   sc_regbank u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .stat_evt  (stat_evt),
      .cnt_evt   (cnt_evt),
      .irq       (irq)
   );

   // entry: {req[3:0], is_read, addr[7:0], data[31:0]} (data = write data or expected)
   localparam int NV = 13;
   localparam logic [44:0] VEC [NV] = '{
      {4'd1,  1'b1, 8'h00, 32'h000A5C30},  // R1 id
      {4'd2,  1'b1, 8'h04, 32'h00000800},  // R2 reset value
      {4'd1,  1'b0, 8'h00, 32'hFFFFFFFF},  // R1 write ignored
      {4'd1,  1'b1, 8'h00, 32'h000A5C30},  // R1
      {4'd2,  1'b0, 8'h04, 32'hFFFFFFFF},  // R2
      {4'd2,  1'b1, 8'h04, 32'h00000803},  // R2 writable bits only
      {4'd2,  1'b0, 8'h04, 32'h00000000},  // R2
      {4'd2,  1'b1, 8'h04, 32'h00000000},  // R2
      {4'd12, 1'b1, 8'h30, 32'h00000000},  // R12 unmapped
      {4'd12, 1'b1, 8'hFC, 32'h00000000},  // R12 unmapped
      {4'd11, 1'b0, 8'h0C, 32'h000000FF},  // R11 enable 0
      {4'd11, 1'b1, 8'h0C, 32'h000000FF},  // R11
      {4'd3,  1'b1, 8'h08, 32'h00000000}   // R3 empty after reset
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [7:0] a, input logic [23:0] sev,
                           input logic [3:0] cev, output logic [31:0] data);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; stat_evt = sev; cnt_evt = cev;
      @(negedge clk);
      data = bus_rdata;
      bus_rd = 1'b0; stat_evt = '0; cnt_evt = '0;
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] wd);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = wd;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic pulse_stat(input logic [23:0] sev);
      @(negedge clk);
      stat_evt = sev;
      @(negedge clk);
      stat_evt = '0;
   endtask

   task automatic hold_cnt(input logic [3:0] cev, input int n);
      @(negedge clk);
      cnt_evt = cev;
      repeat (n) @(negedge clk);
      cnt_evt = '0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 irq after reset", {29'd0, irq}, 32'd0);
      chk("R12 rdata after reset", bus_rdata, 32'd0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         if (VEC[v][40]) begin
            bus_read(VEC[v][39:32], '0, '0, d);
            chk($sformatf("R%0d vector %0d", VEC[v][44:41], v), d, VEC[v][31:0]);
         end else begin
            bus_write(VEC[v][39:32], VEC[v][31:0]);
         end
      end

      // status 0, clear on read
      pulse_stat(24'h000021);
      bus_read(8'h08, '0, '0, d); chk("R3 latch", d, 32'h21);
      bus_read(8'h08, '0, '0, d); chk("R4 cleared by read", d, 32'h0);
      pulse_stat(24'h000002);
      bus_write(8'h08, 32'hFF);
      bus_read(8'h30, '0, '0, d); chk("R12 unmapped", d, 32'h0);
      bus_read(8'h08, '0, '0, d); chk("R3 write ignored R12 no side effect", d, 32'h02);
      pulse_stat(24'h000001);
      bus_read(8'h08, 24'h000008, '0, d); chk("R7 old value on read", d, 32'h01);
      bus_read(8'h08, '0, '0, d); chk("R7 event kept", d, 32'h08);

      // status 1, clear on write
      pulse_stat(24'h001000);
      bus_read(8'h10, '0, '0, d); chk("R5 value", d, 32'h10);
      bus_read(8'h10, '0, '0, d); chk("R5 read keeps", d, 32'h10);
      bus_write(8'h10, 32'hAB);
      bus_read(8'h10, '0, '0, d); chk("R5 write clears", d, 32'h0);

      // status 2, read-or-write select (cfg = 0)
      pulse_stat(24'h010000);
      bus_read(8'h18, '0, '0, d); chk("R6 read mode value", d, 32'h01);
      bus_read(8'h18, '0, '0, d); chk("R6 read mode clears", d, 32'h0);
      bus_write(8'h04, 32'h1);
      pulse_stat(24'h020000);
      bus_read(8'h18, '0, '0, d); chk("R6 write mode value", d, 32'h02);
      bus_read(8'h18, '0, '0, d); chk("R6 write mode read keeps", d, 32'h02);
      bus_write(8'h18, 32'h0);
      bus_read(8'h18, '0, '0, d); chk("R6 write mode write clears", d, 32'h0);

      // interrupts
      pulse_stat(24'h000080);
      chk("R11 irq one cycle late", {29'd0, irq}, 32'd0);
      @(negedge clk);
      chk("R11 irq level 1", {29'd0, irq}, 32'd1);
      bus_read(8'h08, '0, '0, d);
      chk("R11 status read", d, 32'h80);
      chk("R11 irq held during clear", {29'd0, irq}, 32'd1);
      @(negedge clk);
      chk("R11 irq drops", {29'd0, irq}, 32'd0);
      pulse_stat(24'h000100);
      @(negedge clk);
      chk("R11 masked", {29'd0, irq}, 32'd0);
      bus_write(8'h14, 32'h1);
      @(negedge clk);
      chk("R11 enable level 2", {29'd0, irq}, 32'd2);
      bus_write(8'h10, 32'h0);
      @(negedge clk);
      chk("R11 level 2 drops", {29'd0, irq}, 32'd0);

      // counters (cfg = 1)
      hold_cnt(4'b0001, 300);
      bus_read(8'h20, '0, '0, d); chk("R8 saturate", d, 32'd255);
      bus_read(8'h20, '0, '0, d); chk("R4 counter read clears", d, 32'd0);
      hold_cnt(4'b0001, 6);
      bus_read(8'h20, '0, 4'b0001, d); chk("R7 counter old value", d, 32'd6);
      bus_read(8'h20, '0, '0, d); chk("R7 counter restarts at 1", d, 32'd1);
      hold_cnt(4'b0010, 259);
      bus_read(8'h24, '0, '0, d); chk("R9 wrap", d, 32'd3);
      bus_read(8'h24, '0, '0, d); chk("R5 counter read keeps", d, 32'd3);
      bus_write(8'h24, 32'h5A);
      bus_read(8'h24, '0, '0, d); chk("R5 counter write clears", d, 32'd0);
      hold_cnt(4'b0100, 5);
      bus_read(8'h28, '0, '0, d); chk("R10 count", d, 32'd5);
      bus_read(8'h28, '0, '0, d); chk("R10 read never clears", d, 32'd5);
      bus_write(8'h28, 32'h0);
      bus_read(8'h28, '0, '0, d); chk("R10 write never clears", d, 32'd5);
      bus_write(8'h04, 32'h2);
      bus_read(8'h28, '0, '0, d); chk("R10 read-clear enabled value", d, 32'd5);
      bus_read(8'h28, '0, '0, d); chk("R10 read-clear enabled clears", d, 32'd0);
      hold_cnt(4'b1000, 4);
      bus_read(8'h2C, '0, '0, d); chk("R6 counter read mode", d, 32'd4);
      bus_read(8'h2C, '0, '0, d); chk("R6 counter read clears", d, 32'd0);

      finish_run();
   end

endmodule